// File: doc/BRIEF.md
# Question-Answer Watchdog Token Generator

This block produces the 4-bit question token that a question-and-answer watchdog hands to the supervised processor, and it tracks how many answers are still owed in the current event. A 4-bit token counter advances once per completed good event. Each time the counter rolls over, it steps a 4-bit left-shifting LFSR. The LFSR's feedback taps are chosen by a configuration field. A second field selects how the counter and the LFSR are combined into the token. A 2-bit answer counter starts at three. It counts down on each correct answer and returns to three after a wrong answer or a finished good event.

A startup strobe loads the LFSR from a seed and captures both selection fields. It also clears the token counter and restores the answer counter. All three outputs are registered and show the state that results from the inputs sampled at the same edge. Computing the reference answer, window timing and register access belong to other blocks.

Top module: `qa_token_gen`

## Requirements
- R1: After reset, the token counter is 0, the LFSR is 0000b, both selection fields are 00b, the answer count is 3 and the token is 0.
- R2: On a startup strobe, the LFSR loads the seed, the tap and mix selections are captured, the token counter clears to 0 and the answer count goes to 3. The strobe overrides any event pulse in the same cycle.
- R3: Without a strobe, each good-event pulse adds one to the token counter, modulo 16. The new value is visible on the output after that edge.
- R4: The LFSR changes only when the token counter wraps from 15 to 0 on a good event. It changes at that same edge and by exactly one step.
- R5: An LFSR step shifts the register left by one and feeds bit 0 with the XOR of these bits: tap code 00b uses q3,q2; 01b uses q3,q0; 10b uses q3,q1; 11b uses q3,q2,q1,q0. From any nonzero start, tap code 00b returns to that start after 15 steps.
- R6: A step taken while the LFSR holds 0000b sets it to 0001b instead of shifting.
- R7: The token is formed according to the mix code. 00b gives the counter, 01b gives the LFSR, 10b gives counter XOR LFSR, and 11b gives counter XOR the bit-reversed LFSR (bit 3 swapped with bit 0, bit 2 swapped with bit 1).
- R8: A correct-answer pulse with no wrong answer, good event or strobe lowers the answer count by one. A correct answer at count 0 leaves it at 0.
- R9: A wrong-answer or good-event pulse sets the answer count to 3, even when a correct-answer pulse arrives in the same cycle.
- R10: The seed, tap code and mix code inputs have no effect on any output except at a startup strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Startup strobe: load seed and capture selections |
| seed_i | input | 4 | LFSR start value |
| taps_i | input | 2 | LFSR feedback tap code |
| mix_i | input | 2 | Token formation code |
| ans_ok_i | input | 1 | Correct answer pulse |
| ans_bad_i | input | 1 | Wrong answer pulse |
| good_evt_i | input | 1 | Good event completion pulse |
| token_o | output | 4 | Current question token |
| ans_cnt_o | output | 2 | Answers remaining in the event |
| tok_cnt_o | output | 4 | Token counter value |

## Verification
The assertions assume that every pulse input is a single-cycle level sampled at the clock edge. They place no restriction on combinations: the correct-answer, wrong-answer, good-event and startup pulses may all coincide, and the priority rules in the design cover every such case. The random stimulus draws each pulse independently, so coincident pulses arise naturally. It also changes the configuration inputs on every cycle whether or not a strobe is present. Directed sequences cover the all-zero seed, a full 15-step LFSR period, saturation of the answer counter at zero and the strobe-versus-event conflict.

// File: rtl/qa_tok_pkg.sv
package qa_tok_pkg;
  localparam int TOK_W = 4;
  localparam int ANS_W = 2;

  typedef enum logic [1:0] {
    TAP_Q3Q2  = 2'b00,
    TAP_Q3Q0  = 2'b01,
    TAP_Q3Q1  = 2'b10,
    TAP_ALL   = 2'b11
  } tap_e;

  typedef enum logic [1:0] {
    MIX_CNT   = 2'b00,
    MIX_LFSR  = 2'b01,
    MIX_XOR   = 2'b10,
    MIX_XREV  = 2'b11
  } mix_e;
endpackage

// File: rtl/qa_tok_counter.sv
module qa_tok_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d,
  output logic         wrap
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_comb begin
    wrap  = 1'b0;
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R3: a good event without load adds one
  a_r3_count_up: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));
  // R2: load clears the counter
  a_r2_load_clear: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == '0));
endmodule

// File: rtl/qa_tok_lfsr.sv
module qa_tok_lfsr
  import qa_tok_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  tap_e         taps,
  input  logic         step,
  output logic [W-1:0] q,
  output logic [W-1:0] d
);
  logic fb;

  always_comb begin
    unique case (taps)
      TAP_Q3Q2: fb = q[3] ^ q[2];
      TAP_Q3Q0: fb = q[3] ^ q[0];
      TAP_Q3Q1: fb = q[3] ^ q[1];
      default:  fb = ^q;
    endcase
  end

  always_comb begin
    d = q;
    if (load)           d = seed;
    else if (step) begin
      if (q == '0)      d = W'(1);
      else              d = {q[W-2:0], fb};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R6: zero state steps to one
  a_r6_zero_step: assert property (@(posedge clk) disable iff (rst)
    (step && !load && q == '0) |=> (q == W'(1)));
  // R5: a step from a nonzero state never reaches zero and shifts left
  a_r5_shift: assert property (@(posedge clk) disable iff (rst)
    (step && !load && q != '0) |=> (q != '0 && q[W-1:1] == $past(q[W-2:0])));
  // R4: without step or load the register holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(q));
endmodule

// File: rtl/qa_ans_counter.sv
module qa_ans_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restore,
  input  logic         ok,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                   cnt_q <= FULL;
    else if (restore)          cnt_q <= FULL;
    else if (ok && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // R9: restore wins over a correct answer
  a_r9_restore: assert property (@(posedge clk) disable iff (rst)
    restore |=> (cnt_q == FULL));
  // R8: correct answer decrements, saturating at zero
  a_r8_decrement: assert property (@(posedge clk) disable iff (rst)
    (ok && !restore && cnt_q != '0) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));
  a_r8_floor: assert property (@(posedge clk) disable iff (rst)
    (!restore && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/qa_token_gen.sv
module qa_token_gen
  import qa_tok_pkg::*;
#(
  parameter int TW = TOK_W,
  parameter int AW = ANS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [TW-1:0] seed_i,
  input  logic [1:0]    taps_i,
  input  logic [1:0]    mix_i,
  input  logic          ans_ok_i,
  input  logic          ans_bad_i,
  input  logic          good_evt_i,
  output logic [TW-1:0] token_o,
  output logic [AW-1:0] ans_cnt_o,
  output logic [TW-1:0] tok_cnt_o
);
  tap_e          taps_q;
  mix_e          mix_q, mix_d;
  logic [TW-1:0] cnt_q, cnt_d, lfsr_q, lfsr_d, lfsr_rev;
  logic          wrap;
  logic [TW-1:0] token_d;

  assign mix_d = start_i ? mix_e'(mix_i) : mix_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      taps_q <= TAP_Q3Q2;
      mix_q  <= MIX_CNT;
    end else if (start_i) begin
      taps_q <= tap_e'(taps_i);
      mix_q  <= mix_e'(mix_i);
    end
  end

  qa_tok_counter #(.W(TW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .load  (start_i),
    .adv   (good_evt_i),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d),
    .wrap  (wrap)
  );

  qa_tok_lfsr #(.W(TW)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .load (start_i),
    .seed (seed_i),
    .taps (taps_q),
    .step (wrap),
    .q    (lfsr_q),
    .d    (lfsr_d)
  );

  qa_ans_counter #(.W(AW)) u_ans (
    .clk     (clk),
    .rst     (rst),
    .restore (start_i | ans_bad_i | good_evt_i),
    .ok      (ans_ok_i),
    .cnt_q   (ans_cnt_o)
  );

  for (genvar i = 0; i < TW; i++) begin : g_rev
    assign lfsr_rev[i] = lfsr_d[TW-1-i];
  end

  always_comb begin
    unique case (mix_d)
      MIX_CNT:  token_d = cnt_d;
      MIX_LFSR: token_d = lfsr_d;
      MIX_XOR:  token_d = cnt_d ^ lfsr_d;
      default:  token_d = cnt_d ^ lfsr_rev;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) token_o <= '0;
    else     token_o <= token_d;
  end

  assign tok_cnt_o = cnt_q;

  // R10: without a strobe the token tracks only counter and LFSR state
  a_r10_cfg_quiet: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !good_evt_i) |=> $stable(token_o));
  // R4: LFSR moves only together with a counter wrap to zero
  a_r4_wrap_link: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !$stable(lfsr_q)) |-> (cnt_q == '0));
endmodule

// File: tb/qa_token_gen_tb.sv
`timescale 1ns/1ps
module qa_token_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_i, ans_ok_i, ans_bad_i, good_evt_i;
  logic [3:0] seed_i;
  logic [1:0] taps_i, mix_i;
  logic [3:0] token_o, tok_cnt_o;
  logic [1:0] ans_cnt_o;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_cnt, m_lfsr;
  logic [1:0] m_ans, m_taps, m_mix;

  always #2.5 clk = ~clk;

  qa_token_gen dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .seed_i(seed_i),
    .taps_i(taps_i), .mix_i(mix_i), .ans_ok_i(ans_ok_i),
    .ans_bad_i(ans_bad_i), .good_evt_i(good_evt_i),
    .token_o(token_o), .ans_cnt_o(ans_cnt_o), .tok_cnt_o(tok_cnt_o)
  );

  function automatic logic [3:0] f_step(logic [1:0] t, logic [3:0] q);
    logic fb;
    case (t)
      2'b00:   fb = q[3] ^ q[2];
      2'b01:   fb = q[3] ^ q[0];
      2'b10:   fb = q[3] ^ q[1];
      default: fb = q[3] ^ q[2] ^ q[1] ^ q[0];
    endcase
    if (q == 4'd0) return 4'd1;
    return {q[2:0], fb};
  endfunction

  function automatic logic [3:0] f_token(logic [1:0] m, logic [3:0] c, logic [3:0] l);
    case (m)
      2'b00:   return c;
      2'b01:   return l;
      2'b10:   return c ^ l;
      default: return c ^ {l[0], l[1], l[2], l[3]};
    endcase
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R7 token"}, token_o, f_token(m_mix, m_cnt, m_lfsr));
    chk({tag, " R3 counter"}, tok_cnt_o, m_cnt);
    chk({tag, " R8 R9 answers"}, {2'b00, ans_cnt_o}, {2'b00, m_ans});
  endtask

  task automatic cyc(logic s, logic g, logic o, logic b,
                     logic [3:0] sd, logic [1:0] tp, logic [1:0] mx);
    @(negedge clk);
    start_i = s; good_evt_i = g; ans_ok_i = o; ans_bad_i = b;
    seed_i = sd; taps_i = tp; mix_i = mx;
    @(posedge clk);
    if (s) begin
      m_lfsr = sd; m_taps = tp; m_mix = mx; m_cnt = 4'd0; m_ans = 2'd3;
    end else begin
      if (g) begin
        if (m_cnt == 4'hF) m_lfsr = f_step(m_taps, m_lfsr);
        m_cnt = m_cnt + 4'd1;
      end
      if (g || b)                 m_ans = 2'd3;
      else if (o && m_ans != 2'd0) m_ans = m_ans - 2'd1;
    end
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    rst = 1'b1; start_i = 0; good_evt_i = 0; ans_ok_i = 0; ans_bad_i = 0;
    seed_i = 0; taps_i = 0; mix_i = 0;
    m_cnt = 0; m_lfsr = 0; m_ans = 2'd3; m_taps = 0; m_mix = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 token", token_o, 4'd0);
    chk("R1 counter", tok_cnt_o, 4'd0);
    chk("R1 answers", {2'b00, ans_cnt_o}, 4'd3);

    // R2 R6 zero seed, LFSR view
    cyc(1, 0, 0, 0, 4'd0, 2'b00, 2'b01);
    chk("R2 seed loaded", token_o, 4'd0);
    for (int i = 0; i < 15; i++) cyc(0, 1, 0, 0, 4'd0, 2'b00, 2'b01);
    chk("R4 no step before wrap", token_o, 4'd0);
    chk("R3 counter at 15", tok_cnt_o, 4'hF);
    cyc(0, 1, 0, 0, 4'd0, 2'b00, 2'b01);
    chk("R6 zero steps to one", token_o, 4'd1);
    chk("R4 counter wrapped", tok_cnt_o, 4'd0);
    // R5 full period with taps 00b: 15 wraps return to 0001b
    for (int w = 0; w < 15; w++) begin
      for (int i = 0; i < 16; i++) begin
        cyc(0, 1, 0, 0, 4'd0, 2'b00, 2'b01);
        check_all("R5 period");
      end
      if (w == 0) chk("R5 first shift", token_o, 4'd2);
    end
    chk("R5 period returns", token_o, 4'd1);

    // R10 config changes without strobe are ignored
    cyc(1, 0, 0, 0, 4'h9, 2'b01, 2'b00);
    for (int i = 0; i < 20; i++) begin
      cyc(0, (i % 3) == 0, 0, 0, 4'(i), 2'(i), 2'(i + 1));
      check_all("R10 ignored cfg");
    end
    chk("R10 token equals counter", token_o, tok_cnt_o);

    // R8 decrement and floor
    cyc(0, 0, 1, 1, 0, 0, 0);
    chk("R9 wrong beats correct", {2'b00, ans_cnt_o}, 4'd3);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0, 0);
    chk("R8 floor at zero", {2'b00, ans_cnt_o}, 4'd0);
    cyc(0, 1, 1, 0, 0, 0, 0);
    chk("R9 good event restores", {2'b00, ans_cnt_o}, 4'd3);
    // R2 strobe beats good event
    cyc(1, 1, 1, 0, 4'h5, 2'b11, 2'b11);
    chk("R2 strobe clears counter", tok_cnt_o, 4'd0);
    chk("R2 R7 reversed mix", token_o, 4'hA);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 64) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0,
          ($urandom % 10) == 0, 4'($urandom), 2'($urandom), 2'($urandom));
      check_all("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule